// File: doc/BRIEF.md
# Packed Complex Butterfly Unit

This unit performs the add/subtract core of a radix-2 FFT butterfly on integer complex data. Each operand is one 32-bit word that carries a signed 16-bit real part and a signed 16-bit imaginary part, so both components move together in one cycle. The unit takes two operands, A and B. It returns their complex sum and their complex difference, both formed from that same pair in one operation. It has exactly two operand inputs and two result outputs.

The second operand can first be multiplied by a twiddle factor, which comes in the same packed format as a Q15 fraction. The product is rounded back to 16 bits before the add/subtract. Integer complex arithmetic can overflow easily, so every result component is clamped to the signed 16-bit range. A flag records that clamping has happened since reset and stays set. Input and output use valid/ready handshakes. The pipeline has a fixed depth of two stages and stalls as a whole when the output is not taken.

Top module: `cplx_bfly`

## Requirements
- R1: Every data word, at the inputs and at the outputs, keeps the real part in bits 31:16 and the imaginary part in bits 15:0, both in signed two's complement.
- R2: When tw_en_i is 0, sum_o equals A+B and diff_o equals A-B. Each is computed separately for the real and the imaginary component, and both come from the same accepted operand pair.
- R3: Each component of sum_o and diff_o is clamped to the range -32768..32767. A result above that range becomes 0x7FFF and a result below it becomes 0x8000.
- R4: ovf_o goes high together with out_valid_o for the first result whose computation clamped any value, including the twiddle product. After that it stays high until reset. Results that need no clamping leave it low.
- R5: When tw_en_i is 1, B is replaced by B*W before the add/subtract. The real part is (Br*Wr - Bi*Wi + 16384) >>> 15 and the imaginary part is (Br*Wi + Bi*Wr + 16384) >>> 15, each clamped as in R3. Halfway values therefore round upward.
- R6: An operand pair is accepted on a rising edge where in_valid_i and in_ready_o are both 1. Without a stall, its results appear with out_valid_o high after the second rising edge following acceptance. out_valid_o stays low after the first edge. Results come out in acceptance order.
- R7: While out_valid_o is 1 and out_ready_i is 0, in_ready_o is 0, and out_valid_o, sum_o and diff_o hold their values. in_ready_o is 1 whenever out_valid_o is 0 or out_ready_i is 1.
- R8: While rst_ni is low, out_valid_o, ovf_o, sum_o and diff_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand pair is valid |
| in_ready_o | output | 1 | Unit can accept an operand pair |
| a_i | input | 32 | Operand A, packed complex |
| b_i | input | 32 | Operand B, packed complex |
| tw_i | input | 32 | Twiddle factor W, packed Q15 complex |
| tw_en_i | input | 1 | Multiply B by W before the add/subtract |
| out_valid_o | output | 1 | Result pair is valid |
| out_ready_i | input | 1 | Downstream takes the result pair |
| sum_o | output | 32 | A+B (or A+B*W), packed complex |
| diff_o | output | 32 | A-B (or A-B*W), packed complex |
| ovf_o | output | 1 | Sticky clamping flag |

## Verification
The add/subtract path is tried with operands whose real and imaginary parts differ in value and sign. This shows whether the two halves of a word are swapped, or whether the sum and the difference are crossed. The twiddle path is tried with a near-unit real twiddle, with a pure imaginary twiddle that rotates B, and with a general twiddle. A half-scale twiddle on ±3 checks rounding: it separates round-half-up from truncation and from symmetric rounding. Extreme operands that overflow the sum, the difference and the product each check clamping and the sticky flag on its own. A back-to-back pair under backpressure checks the stall and the result order.

// File: rtl/cbf_pkg.sv
package cbf_pkg;
  localparam int CBF_CW   = 16;          // component width
  localparam int CBF_FRAC = CBF_CW - 1;  // twiddle fraction bits
endpackage

// File: rtl/cbf_sat.sv
module cbf_sat #(
  parameter int IN_W  = 18,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o,
  output logic             ovf_o
);
  localparam int HI_W = IN_W - OUT_W + 1;

  logic [HI_W-1:0] hi;
  assign hi    = val_i[IN_W-1:OUT_W-1];
  assign ovf_o = !((&hi) || !(|hi));

  always_comb begin
    if (!ovf_o)           val_o = val_i[OUT_W-1:0];
    else if (val_i[IN_W-1]) val_o = {1'b1, {(OUT_W-1){1'b0}}};
    else                  val_o = {1'b0, {(OUT_W-1){1'b1}}};
  end
endmodule

// File: rtl/cbf_cmul.sv
module cbf_cmul #(
  parameter int CW = cbf_pkg::CBF_CW,
  localparam int W = 2*CW
) (
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] w_i,
  input  logic         en_i,
  output logic [W-1:0] b_o,
  output logic         ovf_o
);
  localparam int FRAC = CW - 1;
  localparam int PW   = 2*CW;
  localparam int SW   = PW - FRAC + 1;
  localparam logic signed [PW:0] RND = (PW+1)'(1) <<< (FRAC-1);

  logic signed [CW-1:0] br, bi, wr, wi;
  assign br = b_i[W-1:CW];
  assign bi = b_i[CW-1:0];
  assign wr = w_i[W-1:CW];
  assign wi = w_i[CW-1:0];

  logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;
  assign p_rr = br * wr;
  assign p_ii = bi * wi;
  assign p_ri = br * wi;
  assign p_ir = bi * wr;

  logic signed [PW:0] acc [2];
  assign acc[1] = $signed({p_rr[PW-1], p_rr}) - $signed({p_ii[PW-1], p_ii}) + RND;
  assign acc[0] = $signed({p_ri[PW-1], p_ri}) + $signed({p_ir[PW-1], p_ir}) + RND;

  logic [CW-1:0] prod [2];
  logic [1:0]    sat_ovf;
  logic          unused_lo;
  assign unused_lo = ^{acc[1][FRAC-1:0], acc[0][FRAC-1:0]};

  for (genvar k = 0; k < 2; k++) begin : g_comp
    cbf_sat #(.IN_W(SW), .OUT_W(CW)) u_sat (
      .val_i (acc[k][PW:FRAC]),
      .val_o (prod[k]),
      .ovf_o (sat_ovf[k])
    );
  end

  assign b_o   = en_i ? {prod[1], prod[0]} : b_i;
  assign ovf_o = en_i && (|sat_ovf);
endmodule

// File: rtl/cbf_addsub.sv
module cbf_addsub #(
  parameter int CW = cbf_pkg::CBF_CW,
  localparam int W = 2*CW
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] diff_o,
  output logic         ovf_o
);
  logic [3:0] flags;

  for (genvar k = 0; k < 2; k++) begin : g_comp
    logic signed [CW-1:0] ak, bk;
    logic signed [CW:0]   s_wide, d_wide;
    assign ak     = a_i[k*CW +: CW];
    assign bk     = b_i[k*CW +: CW];
    assign s_wide = {ak[CW-1], ak} + {bk[CW-1], bk};
    assign d_wide = {ak[CW-1], ak} - {bk[CW-1], bk};

    cbf_sat #(.IN_W(CW+1), .OUT_W(CW)) u_sat_s (
      .val_i (s_wide),
      .val_o (sum_o[k*CW +: CW]),
      .ovf_o (flags[2*k])
    );
    cbf_sat #(.IN_W(CW+1), .OUT_W(CW)) u_sat_d (
      .val_i (d_wide),
      .val_o (diff_o[k*CW +: CW]),
      .ovf_o (flags[2*k+1])
    );
  end

  assign ovf_o = |flags;
endmodule

// File: rtl/cplx_bfly.sv
module cplx_bfly #(
  parameter int CW = cbf_pkg::CBF_CW,
  localparam int W = 2*CW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] tw_i,
  input  logic         tw_en_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] diff_o,
  output logic         ovf_o
);
  logic         adv;
  logic [W-1:0] b_tw;
  logic         tw_ovf;

  logic         s1_vld, s1_ovf;
  logic [W-1:0] s1_a, s1_b;

  logic [W-1:0] as_sum, as_diff;
  logic         as_ovf;

  logic         s2_vld, ovf_q;
  logic [W-1:0] sum_q, diff_q;

  // whole pipe advances unless the output is held
  assign adv        = !s2_vld || out_ready_i;
  assign in_ready_o = adv;

  cbf_cmul #(.CW(CW)) u_cmul (
    .b_i   (b_i),
    .w_i   (tw_i),
    .en_i  (tw_en_i),
    .b_o   (b_tw),
    .ovf_o (tw_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld <= 1'b0;
      s1_ovf <= 1'b0;
      s1_a   <= '0;
      s1_b   <= '0;
    end else if (adv) begin
      s1_vld <= in_valid_i;
      if (in_valid_i) begin
        s1_a   <= a_i;
        s1_b   <= b_tw;
        s1_ovf <= tw_ovf;
      end
    end
  end

  cbf_addsub #(.CW(CW)) u_addsub (
    .a_i    (s1_a),
    .b_i    (s1_b),
    .sum_o  (as_sum),
    .diff_o (as_diff),
    .ovf_o  (as_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld <= 1'b0;
      sum_q  <= '0;
      diff_q <= '0;
      ovf_q  <= 1'b0;
    end else if (adv) begin
      s2_vld <= s1_vld;
      if (s1_vld) begin
        sum_q  <= as_sum;
        diff_q <= as_diff;
        if (s1_ovf || as_ovf) ovf_q <= 1'b1;
      end
    end
  end

  assign out_valid_o = s2_vld;
  assign sum_o       = sum_q;
  assign diff_o      = diff_q;
  assign ovf_o       = ovf_q;
endmodule

// File: rtl/cplx_bfly_chk.sv
module cplx_bfly_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         in_valid_i,
  input logic         in_ready_o,
  input logic         out_valid_o,
  input logic         out_ready_i,
  input logic [W-1:0] sum_o,
  input logic [W-1:0] diff_o,
  input logic         ovf_o
);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(sum_o) && $stable(diff_o)));

  a_r7_no_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  a_r7_ready_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!out_valid_o || out_ready_i) |-> in_ready_o);

  a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  a_r4_with_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> out_valid_o);

  a_r6_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(in_valid_i && in_ready_o, 2));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r8_reset_idle: assert (!out_valid_o && !ovf_o && sum_o == '0 && diff_o == '0);
    end
  end
endmodule

bind cplx_bfly cplx_bfly_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .sum_o       (sum_o),
  .diff_o      (diff_o),
  .ovf_o       (ovf_o)
);

// File: tb/cplx_bfly_tb.sv
`timescale 1ns/1ps
module cplx_bfly_tb;
  typedef struct packed {
    logic [15:0] tag;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] w;
    logic        en;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{"R1", 32'h0003_0005, 32'h0001_FFFE, 32'h0000_0000, 1'b0},
    '{"R2", 32'h7FFF_8000, 32'h0000_0000, 32'h0000_0000, 1'b0},
    '{"R2", 32'h1234_F00D, 32'hFEDC_0777, 32'h0000_0000, 1'b0},
    '{"R5", 32'h0000_0000, 32'h4000_C000, 32'h7FFF_0000, 1'b1},
    '{"R5", 32'h0000_0000, 32'h0003_FFFD, 32'h4000_0000, 1'b1},
    '{"R5", 32'h0010_0020, 32'h0064_00C8, 32'h0000_7FFF, 1'b1},
    '{"R5", 32'h0100_FF00, 32'h2000_1000, 32'h5A82_A57E, 1'b1},
    '{"R3", 32'h7FFF_0001, 32'h0001_0001, 32'h0000_0000, 1'b0},
    '{"R3", 32'h0000_0000, 32'h8000_0000, 32'h8000_0000, 1'b1},
    '{"R3", 32'h8000_0000, 32'h0001_0000, 32'h0000_0000, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] a_i = '0, b_i = '0, tw_i = '0;
  logic        tw_en_i = 1'b0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic [31:0] sum_o, diff_o;
  logic        ovf_o;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  exp_ovf = 1'b0;
  bit  sat_hit;

  always #2.5 clk = ~clk;

  cplx_bfly u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .a_i(a_i), .b_i(b_i), .tw_i(tw_i), .tw_en_i(tw_en_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .sum_o(sum_o), .diff_o(diff_o), .ovf_o(ovf_o)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] clamp(input longint v);
    if (v > 32767)  begin sat_hit = 1'b1; return 16'h7FFF; end
    if (v < -32768) begin sat_hit = 1'b1; return 16'h8000; end
    return v[15:0];
  endfunction

  function automatic longint hi(input logic [31:0] x); return longint'($signed(x[31:16])); endfunction
  function automatic longint lo(input logic [31:0] x); return longint'($signed(x[15:0])); endfunction

  // reference from R2, R3, R5
  task automatic model(input vec_t v, output logic [31:0] s, output logic [31:0] d);
    longint nr, ni;
    logic [15:0] tr, ti;
    sat_hit = 1'b0;
    nr = hi(v.b);
    ni = lo(v.b);
    if (v.en) begin
      tr = clamp((hi(v.b)*hi(v.w) - lo(v.b)*lo(v.w) + 16384) >>> 15);
      ti = clamp((hi(v.b)*lo(v.w) + lo(v.b)*hi(v.w) + 16384) >>> 15);
      nr = longint'($signed(tr));
      ni = longint'($signed(ti));
    end
    s = {clamp(hi(v.a) + nr), clamp(lo(v.a) + ni)};
    d = {clamp(hi(v.a) - nr), clamp(lo(v.a) - ni)};
    if (sat_hit) exp_ovf = 1'b1;
  endtask

  task automatic drive(input vec_t v);
    a_i = v.a; b_i = v.b; tw_i = v.w; tw_en_i = v.en; in_valid_i = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R6 watchdog: actual=hung expected=complete");
    finish_run();
  end

  initial begin
    logic [31:0] es, ed;
    vec_t v1, v2;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8", "valid in reset", 32'(out_valid_o), 32'd0);
    check("R8", "ovf in reset", 32'(ovf_o), 32'd0);
    check("R8", "sum in reset", sum_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string t;
      t = $sformatf("%s", VECS[i].tag);
      model(VECS[i], es, ed);
      check("R7", "ready idle", 32'(in_ready_o), 32'd1);
      drive(VECS[i]);
      @(posedge clk);
      @(negedge clk);
      in_valid_i = 1'b0;
      check("R6", "valid after 1 edge", 32'(out_valid_o), 32'd0);
      @(posedge clk);
      @(negedge clk);
      check("R6", "valid after 2 edges", 32'(out_valid_o), 32'd1);
      check(t, "sum", sum_o, es);
      check(t, "diff", diff_o, ed);
      check("R4", "sticky flag", 32'(ovf_o), 32'(exp_ovf));
      @(negedge clk);
    end

    // R5 rounding: +1.5 -> 2, -1.5 -> -1
    check("R5", "ovf set by end", 32'(ovf_o), 32'd1);

    // R7 backpressure, two back-to-back ops
    out_ready_i = 1'b0;
    v1 = '{"R7", 32'h0010_0020, 32'h0001_0002, 32'h0, 1'b0};
    v2 = '{"R7", 32'h0100_0200, 32'h0003_0004, 32'h0, 1'b0};
    drive(v1);
    @(posedge clk);
    @(negedge clk);
    drive(v2);
    @(posedge clk);
    @(negedge clk);
    in_valid_i = 1'b0;
    check("R7", "held valid", 32'(out_valid_o), 32'd1);
    check("R7", "first result", sum_o, 32'h0011_0022);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      check("R7", "ready low in stall", 32'(in_ready_o), 32'd0);
      check("R7", "sum held", sum_o, 32'h0011_0022);
      check("R7", "diff held", diff_o, 32'h000F_001E);
    end
    out_ready_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R6", "second result in order", sum_o, 32'h0103_0204);
    check("R6", "second valid", 32'(out_valid_o), 32'd1);
    @(posedge clk);
    @(negedge clk);
    check("R6", "drained", 32'(out_valid_o), 32'd0);

    // R8 reset clears sticky flag
    rst_ni = 1'b0;
    @(negedge clk);
    check("R8", "ovf cleared", 32'(ovf_o), 32'd0);
    check("R8", "diff cleared", diff_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R4: non-clamping op after reset leaves flag low
    exp_ovf = 1'b0;
    v1 = '{"R4", 32'h0005_0005, 32'h0002_0003, 32'h0, 1'b0};
    drive(v1);
    @(posedge clk);
    @(negedge clk);
    in_valid_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R4", "no clamp no flag", 32'(ovf_o), 32'd0);
    check("R2", "diff", diff_o, 32'h0003_0002);

    // R5 rounding direction, hand values
    v1 = '{"R5", 32'h0, 32'h0003_FFFD, 32'h4000_0000, 1'b1};
    drive(v1);
    @(posedge clk);
    @(negedge clk);
    in_valid_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R5", "half-up rounding", sum_o, 32'h0002_FFFF);

    finish_run();
  end
endmodule